// File: doc/BRIEF.md
# Memory controller operating-state machine

This block holds the operating state of a DRAM protocol controller and exposes it through a small word-wide register bus. Software drives it by writing a command word to a control register. It learns the outcome only by polling a status register, because the block has no handshake line. Three states exist: a configuration state, a normal access state, and a low-power state in which the memory is in self-refresh.

A command is taken only when it is legal from the current state. An accepted command starts a settling window whose length is a parameter. The status register keeps showing the old state until that window ends. A command that is illegal, or that arrives while a window is still open, is dropped and sets a sticky error flag. A separate configuration word holds one enable bit for a data-test unit; that bit has no effect on the state machine.

Top module: `mem_opstate_ctrl`

## Requirements
- R1: After reset the status register reads 0x00000001 (configuration state, error flag clear), and the test-unit configuration register reads 0.
- R2: A write to byte offset 0x004 issues a command. The whole 32-bit word must equal one of CFG=1, GO=2, SLEEP=3 or WAKEUP=4, and any other value is illegal. The status register at offset 0x008 carries the state code in bits [2:0] (CONFIG=1, ACCESS=3, LOW_POWER=5), the error flag in bit 31, and zero in every other bit.
- R3: SLEEP accepted in ACCESS moves the state to LOW_POWER (self-refresh active).
- R4: WAKEUP accepted in LOW_POWER moves the state to ACCESS.
- R5: CFG accepted in ACCESS moves the state to CONFIG, and GO accepted in CONFIG moves the state to ACCESS.
- R6: The new state appears in the status register SETTLE_CYCLES rising edges after the edge that samples the accepted command write. Until then the old state is reported. With READ_LATENCY=1, read data lags by one further edge.
- R7: A command that is illegal for the current state, or that is written while a transition is still settling, leaves the state unchanged and sets status bit 31.
- R8: Once set, status bit 31 stays set until reset, including across later legal transitions.
- R9: Offset 0x208 holds a test-unit enable in bit 0. A write stores wr_data[0], and the other bits read as zero.
- R10: Reads of any other offset, including the control register, return 0. Writes to any other offset change neither the state nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | DATA_W | Read data, combinational or registered per READ_LATENCY |

## Verification
Directed sequences walk every legal edge of the state graph once and sample the status on each edge of a settling window, which separates an off-by-one in the timer from a wrong target state. Illegal commands are tried in three forms: a known code in the wrong state, a word that matches no code, and a legal code sent during a window. These show apart the legality table, the exact-word decode and the busy guard. Seeded random phases then alternate between runs biased to legal commands, which exercise long chains of timed transitions, and unbiased runs, which mix bus noise to other offsets with error cases. Every cycle of these phases is compared against a bench model.

// File: rtl/opstate_pkg.sv
package opstate_pkg;

   typedef enum logic [2:0] {
      ST_CONFIG = 3'd1,
      ST_ACCESS = 3'd3,
      ST_LOWPWR = 3'd5
   } opstate_e;

   localparam int CMD_CFG   = 1;
   localparam int CMD_GO    = 2;
   localparam int CMD_SLEEP = 3;
   localparam int CMD_WAKE  = 4;

   localparam int OFS_CTRL = 'h004;
   localparam int OFS_STAT = 'h008;
   localparam int OFS_DIAG = 'h208;

endpackage

// File: rtl/opstate_cmd_check.sv
module opstate_cmd_check
   import opstate_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  opstate_e            cur_state,
   input  logic [DATA_W-1:0]   cmd_word,
   output logic                legal,
   output opstate_e            target
);

   localparam logic [DATA_W-1:0] W_CFG   = DATA_W'(CMD_CFG);
   localparam logic [DATA_W-1:0] W_GO    = DATA_W'(CMD_GO);
   localparam logic [DATA_W-1:0] W_SLEEP = DATA_W'(CMD_SLEEP);
   localparam logic [DATA_W-1:0] W_WAKE  = DATA_W'(CMD_WAKE);

   always_comb begin
      legal  = 1'b0;
      target = cur_state;
      unique case (cur_state)
         ST_CONFIG: begin
            if (cmd_word == W_GO) begin
               legal  = 1'b1;
               target = ST_ACCESS;
            end
         end
         ST_ACCESS: begin
            if (cmd_word == W_SLEEP) begin
               legal  = 1'b1;
               target = ST_LOWPWR;
            end else if (cmd_word == W_CFG) begin
               legal  = 1'b1;
               target = ST_CONFIG;
            end
         end
         ST_LOWPWR: begin
            if (cmd_word == W_WAKE) begin
               legal  = 1'b1;
               target = ST_ACCESS;
            end
         end
         default: begin
            legal  = 1'b0;
            target = cur_state;
         end
      endcase
   end

endmodule

// File: rtl/opstate_settle.sv
module opstate_settle #(
   parameter int SETTLE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);

   localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (busy) begin
         if (cnt_q == '0) busy  <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= LOAD;
      end
   end

   assign done = busy && (cnt_q == '0);

endmodule

// File: rtl/mem_opstate_ctrl.sv
module mem_opstate_ctrl
   import opstate_pkg::*;
#(
   parameter int ADDR_W        = 12,
   parameter int DATA_W        = 32,
   parameter int SETTLE_CYCLES = 4,
   parameter int READ_LATENCY  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_DIAG = ADDR_W'(OFS_DIAG);
   localparam int ERR_BIT = DATA_W - 1;

   initial begin
      assert (ADDR_W >= 10 && ADDR_W <= 32)
         else $error("ADDR_W must reach offset 0x208");
      assert (DATA_W >= 8 && DATA_W <= 64)
         else $error("DATA_W out of range");
      assert (SETTLE_CYCLES >= 1)
         else $error("SETTLE_CYCLES must be at least 1");
      assert (READ_LATENCY == 0 || READ_LATENCY == 1)
         else $error("READ_LATENCY must be 0 or 1");
   end

   opstate_e state_q, target_q, target_d;
   logic     err_q, diag_q;
   logic     busy, done, legal;
   logic     cmd_wr, accept, reject;

   opstate_cmd_check #(.DATA_W(DATA_W)) u_check (
      .cur_state (state_q),
      .cmd_word  (wr_data),
      .legal     (legal),
      .target    (target_d)
   );

   assign cmd_wr = wr_en && (wr_addr == A_CTRL);
   assign accept = cmd_wr && !busy && legal;
   assign reject = cmd_wr && (busy || !legal);

   opstate_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .busy  (busy),
      .done  (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_CONFIG;
         target_q <= ST_CONFIG;
         err_q    <= 1'b0;
         diag_q   <= 1'b0;
      end else begin
         if (accept)  target_q <= target_d;
         if (done)    state_q  <= target_q;
         if (reject)  err_q    <= 1'b1;
         if (wr_en && (wr_addr == A_DIAG)) diag_q <= wr_data[0];
      end
   end

   logic [DATA_W-1:0] rd_word;

   always_comb begin
      rd_word = '0;
      if (rd_addr == A_STAT) begin
         rd_word[2:0]     = state_q;
         rd_word[ERR_BIT] = err_q;
      end else if (rd_addr == A_DIAG) begin
         rd_word[0] = diag_q;
      end
   end

   generate
      if (READ_LATENCY == 0) begin : g_rd_comb
         assign rd_data = rd_word;
      end else begin : g_rd_reg
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_word;
         end
         assign rd_data = rd_q;
      end
   endgenerate

endmodule

// File: rtl/opstate_checker.sv
module opstate_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] state_q,
   input logic       busy,
   input logic       err_q
);

   AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == 3'd1 || state_q == 3'd3 || state_q == 3'd5)); // R2

   AST_ENTER_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == 3'd5 && $past(state_q) != 3'd5) |-> $past(state_q) == 3'd3); // R3

   AST_LEAVE_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == 3'd5 && state_q != 3'd5) |-> state_q == 3'd3); // R4

   AST_ENTER_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == 3'd1 && $past(state_q) != 3'd1) |-> $past(state_q) == 3'd3); // R5

   AST_CHANGE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != $past(state_q)) |-> $past(busy)); // R6

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q); // R8

endmodule

bind mem_opstate_ctrl opstate_checker u_opstate_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .state_q (state_q),
   .busy    (busy),
   .err_q   (err_q)
);

// File: tb/mem_opstate_ctrl_bench.sv
module mem_opstate_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 4;
   localparam int RD_LAT     = 0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [11:0] rd_addr = 12'h008;
   logic [31:0] rd_data;

   int n_cmp = 0;
   int n_bad = 0;

   int m_state, m_tgt, m_cnt;
   bit m_busy, m_err, m_diag;
   logic [31:0] exp_pre, exp_cur;

   always #(CLK_PERIOD/2) clk = ~clk;

   mem_opstate_ctrl #(
      .ADDR_W(12), .DATA_W(32), .SETTLE_CYCLES(SETTLE), .READ_LATENCY(RD_LAT)
   ) u_mem_opstate_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic logic [31:0] stat_word(bit e, int st);
      return {e, 28'd0, st[2:0]};
   endfunction

   // Legal successor per R3..R5, 0 when illegal (R7).
   function automatic int next_of(int st, logic [31:0] cmd);
      if (st == 1 && cmd == 32'd2) return 3;
      if (st == 3 && cmd == 32'd3) return 5;
      if (st == 3 && cmd == 32'd1) return 1;
      if (st == 5 && cmd == 32'd4) return 3;
      return 0;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_state = 1; m_tgt = 1; m_cnt = 0; m_busy = 0; m_err = 0; m_diag = 0;
      exp_pre = stat_word(0, 1); exp_cur = exp_pre;
   endtask

   task automatic model_edge(bit w, logic [11:0] a, logic [31:0] d);
      bit was_busy = m_busy;
      int nx = next_of(m_state, d);
      exp_pre = stat_word(m_err, m_state);
      if (w && a == 12'h004 && (was_busy || nx == 0)) m_err = 1;
      if (w && a == 12'h208) m_diag = d[0];
      if (was_busy) begin
         if (m_cnt == 0) begin m_state = m_tgt; m_busy = 0; end
         else m_cnt--;
      end else if (w && a == 12'h004 && nx != 0) begin
         m_busy = 1; m_cnt = SETTLE - 1; m_tgt = nx;
      end
      exp_cur = stat_word(m_err, m_state);
   endtask

   task automatic cycle(bit w, logic [11:0] a, logic [31:0] d);
      wr_en = w; wr_addr = a; wr_data = d;
      @(posedge clk);
      model_edge(w, a, d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [31:0] exp_stat();
      return (RD_LAT == 0) ? exp_cur : exp_pre;
   endfunction

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cycle(0, 12'h000, 32'd0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; wr_en = 1'b0; rd_addr = 12'h008;
      repeat (3) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic read_at(logic [11:0] a, output logic [31:0] v);
      rd_addr = a;
      if (RD_LAT == 0) #1;
      else cycle(0, 12'h000, 32'd0);
      v = rd_data;
      rd_addr = 12'h008;
      #1;
   endtask

   task automatic settle_and_check(string req, int exp_st);
      idle(SETTLE + RD_LAT);
      check(req, rd_data, stat_word(m_err, exp_st));
   endtask

   int choose_legal;

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      model_reset();
      do_reset();

      // R1 reset state
      check("R1 status after reset", rd_data, 32'h0000_0001);
      read_at(12'h208, v);
      check("R1 test-unit enable after reset", v, 32'd0);

      // R6 exact settle timing: GO from CONFIG
      cycle(1, 12'h004, 32'd2);
      for (int e = 1; e <= SETTLE + RD_LAT; e++) begin
         if (e == 1) check("R6 old state right after accept", rd_data, 32'd1);
         cycle(0, 12'h000, 32'd0);
         check("R6 settle window edge", rd_data,
               (e >= SETTLE + RD_LAT) ? 32'd3 : 32'd1);
      end

      // R3 / R4 / R5 walk
      cycle(1, 12'h004, 32'd3);
      settle_and_check("R3 SLEEP in ACCESS", 5);
      cycle(1, 12'h004, 32'd4);
      settle_and_check("R4 WAKEUP in LOW_POWER", 3);
      cycle(1, 12'h004, 32'd1);
      settle_and_check("R5 CFG in ACCESS", 1);
      cycle(1, 12'h004, 32'd2);
      settle_and_check("R5 GO in CONFIG", 3);
      check("R7 no error on legal walk", rd_data[31], 1'b0);

      // R10 other offsets
      read_at(12'h004, v);
      check("R10 control offset reads zero", v, 32'd0);
      cycle(1, 12'h010, 32'd3);
      settle_and_check("R10 write elsewhere ignored", 3);

      // R7 wrong code for state
      cycle(1, 12'h004, 32'd4);
      settle_and_check("R7 WAKEUP in ACCESS ignored", 3);
      check("R7 error bit set", rd_data, 32'h8000_0003);

      // R8 sticky across legal transitions
      cycle(1, 12'h004, 32'd3);
      settle_and_check("R8 error kept after SLEEP", 5);
      check("R8 error bit still set", rd_data[31], 1'b1);

      // R7 command during settle window, and non-exact word
      do_reset();
      cycle(1, 12'h004, 32'd2);
      cycle(1, 12'h004, 32'd3);
      settle_and_check("R7 command while settling dropped", 3);
      check("R7 busy reject flagged", rd_data[31], 1'b1);
      do_reset();
      cycle(1, 12'h004, 32'h0000_0102);
      settle_and_check("R7 non-exact word ignored", 1);
      check("R7 non-exact word flagged", rd_data, 32'h8000_0001);

      // R9 test-unit enable bit
      cycle(1, 12'h208, 32'hFFFF_FFFE);
      read_at(12'h208, v);
      check("R9 enable cleared", v, 32'd0);
      cycle(1, 12'h208, 32'hFFFF_FFFF);
      read_at(12'h208, v);
      check("R9 enable set, upper bits zero", v, 32'd1);
      check("R9 status untouched", rd_data, exp_stat());

      // Random phases compared against the model every cycle
      for (int p = 0; p < 8; p++) begin
         do_reset();
         choose_legal = (p % 2 == 0);
         for (int i = 0; i < 500; i++) begin
            bit w = ($urandom % 3) != 0;
            logic [11:0] a;
            logic [31:0] d;
            int r = $urandom % 8;
            if (r < 5) a = 12'h004;
            else if (r == 5) a = 12'h208;
            else if (r == 6) a = 12'h008;
            else a = 12'($urandom) & 12'hFFC;
            if (choose_legal != 0) begin
               if (m_state == 1) d = 32'd2;
               else if (m_state == 5) d = 32'd4;
               else d = ($urandom % 2) ? 32'd1 : 32'd3;
               if (m_busy) w = 1'b0;
            end else begin
               d = (($urandom % 6) < 4) ? 32'(1 + $urandom % 4) : $urandom;
            end
            cycle(w, a, d);
            check("R6 random status vs model", rd_data, exp_stat());
         end
         read_at(12'h208, v);
         check("R9 random enable vs model", v, {31'd0, m_diag});
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule